// File: doc/BRIEF.md
# Multi-Port RAM with Per-Pair Write Bypass

This block is a word-addressable storage array with a configurable number of write ports and read ports, all on one clock. Each write port stores its data under a lane-granular enable, so a caller can update any subset of equal-width lanes of a word. Each read port is built either as a combinational port that follows its address, or as a registered port with its own read enable.

A registered read port can be told, per write port, to forward that port's same-cycle write data. The choice is made by one mask bit per read/write pair. When forwarding is on and the addresses match, the returned word mixes the new data on the written lanes with the stored data on the others. When forwarding is off, the returned word is the stored word from before the write. A global clock-enable gates every write and every registered read. The contents after reset come from a parameter word list.

Top module: `mp_ram`

## Requirements
- R1: The enable of each write port has LANES bits, and each bit controls WIDTH/LANES data bits. Enable bit l covers data bits [l*LW +: LW]. A write changes only the lanes whose enable bit is set. The stored word keeps its old value on every other lane.
- R2: When more than one write port targets the same in-range address in one cycle, the highest-indexed port's data is stored on each lane that several of them enable.
- R3: A combinational read port (RD_SYNC bit 0) shows the stored word at its address in the same cycle. It ignores its read enable, ignores the forwarding mask, and shows the contents from before a write in that cycle. The new word appears after the clock edge.
- R4: A registered read port (RD_SYNC bit 1) with its enable high and the clock-enable high loads its output at the clock edge. If no write port it forwards from hits its address, it loads the word stored before that edge's writes.
- R5: A registered read port holds its output while its read enable is low.
- R6: Mask bit r*NWR+w set means registered read port r forwards write port w. On an address match with an in-range address, the lanes that w enables come from w's data and the other lanes come from the stored word. Forwarding is applied in ascending write-port order, so a higher-indexed port wins.
- R7: A read from an address at or above DEPTH returns zero on both kinds of read port. No forwarding is applied to such a read.
- R8: A write to an address at or above DEPTH leaves every stored word unchanged.
- R9: During and after reset, word i holds INIT_DATA[i*WIDTH +: WIDTH] for i < INIT_LEN and zero otherwise, and registered read outputs are zero. An INIT_LEN above DEPTH is an elaboration error.
- R10: While `ce` is low, no word is written and every registered read output holds. Combinational reads still follow their address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all ports |
| rst_n | input | 1 | Asynchronous active-low reset, reloads the initial image |
| ce | input | 1 | Global clock-enable for writes and registered reads |
| wr_addr | input | NWR*AW | Write addresses, port w at [w*AW +: AW] |
| wr_data | input | NWR*WIDTH | Write data, port w at [w*WIDTH +: WIDTH] |
| wr_en | input | NWR*LANES | Lane enables, port w at [w*LANES +: LANES] |
| rd_addr | input | NRD*AW | Read addresses, port r at [r*AW +: AW] |
| rd_en | input | NRD | Read enables, used by registered ports only |
| rd_data | output | NRD*WIDTH | Read data, port r at [r*WIDTH +: WIDTH] |

## Verification
The default build has two registered read ports and one combinational read port. Port 0 forwards both writers and port 1 forwards only writer 1. Reading the same address through ports 0 and 1 while writer 0 or writer 1 stores therefore shows whether forwarding follows the mask bit per pair, or is applied to every port at once. Sparse lane enables such as 0101 distinguish a lane-wise merge from a whole-word replacement, and two writers hitting one address with overlapping enables show which port has priority. Out-of-range addresses (12 to 15 for a depth of 12), a low clock-enable, and a long random run with clustered addresses are compared each cycle against a behavioural model of the array.

// File: rtl/mp_ram.sv
module mp_ram #(
  parameter int WIDTH    = 16,
  parameter int LANES    = 4,
  parameter int DEPTH    = 12,
  parameter int NWR      = 2,
  parameter int NRD      = 3,
  parameter logic [NRD-1:0]     RD_SYNC = 3'b011,
  parameter logic [NRD*NWR-1:0] TRANSP  = 6'b001011,
  parameter int INIT_LEN = 4,
  parameter logic [INIT_LEN*WIDTH-1:0] INIT_DATA = 64'h4D4D_3C3C_2B2B_1A1A,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ce,
  input  logic [NWR*AW-1:0]    wr_addr,
  input  logic [NWR*WIDTH-1:0] wr_data,
  input  logic [NWR*LANES-1:0] wr_en,
  input  logic [NRD*AW-1:0]    rd_addr,
  input  logic [NRD-1:0]       rd_en,
  output logic [NRD*WIDTH-1:0] rd_data
);
  localparam int LW = WIDTH / LANES;

  if (WIDTH % LANES != 0) begin : g_bad_lanes
    $error("mp_ram: WIDTH must be a multiple of LANES");
  end
  if (INIT_LEN > DEPTH) begin : g_bad_init
    $error("mp_ram: INIT_LEN exceeds DEPTH");
  end

  function automatic logic [DEPTH-1:0][WIDTH-1:0] init_image();
    logic [DEPTH-1:0][WIDTH-1:0] img;
    img = '0;
    for (int i = 0; i < INIT_LEN && i < DEPTH; i++)
      img[i] = INIT_DATA[i*WIDTH +: WIDTH];
    return img;
  endfunction

  localparam logic [DEPTH-1:0][WIDTH-1:0] INIT_IMG = init_image();

  logic [DEPTH-1:0][WIDTH-1:0] mem_q, mem_d;
  logic any_wr;

  always_comb begin
    logic [AW-1:0] wa;
    wa     = '0;
    mem_d  = mem_q;
    any_wr = 1'b0;
    for (int w = 0; w < NWR; w++) begin
      wa = wr_addr[w*AW +: AW];
      if (int'(wa) < DEPTH) begin
        for (int l = 0; l < LANES; l++) begin
          if (ce && wr_en[w*LANES + l]) begin
            mem_d[wa][l*LW +: LW] = wr_data[w*WIDTH + l*LW +: LW];
            any_wr = 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mem_q <= INIT_IMG;
    else        mem_q <= mem_d;
  end

  // R10
  ce_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ce |=> $stable(mem_q));

  // R8
  no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !any_wr |=> $stable(mem_q));

  for (genvar r = 0; r < NRD; r++) begin : g_rd
    logic [AW-1:0]    ra;
    logic             in_rng;
    logic [WIDTH-1:0] stored;

    assign ra     = rd_addr[r*AW +: AW];
    assign in_rng = int'(ra) < DEPTH;
    assign stored = in_rng ? mem_q[ra] : '0;

    if (RD_SYNC[r]) begin : g_sync
      logic [WIDTH-1:0] q, byp;

      always_comb begin
        byp = stored;
        if (in_rng && ce) begin
          for (int w = 0; w < NWR; w++) begin
            if (TRANSP[r*NWR + w] && wr_addr[w*AW +: AW] == ra) begin
              for (int l = 0; l < LANES; l++)
                if (wr_en[w*LANES + l])
                  byp[l*LW +: LW] = wr_data[w*WIDTH + l*LW +: LW];
            end
          end
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            q <= '0;
        else if (rd_en[r] && ce) q <= byp;
      end

      assign rd_data[r*WIDTH +: WIDTH] = q;

      // R5
      rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en[r] && ce) |=> $stable(rd_data[r*WIDTH +: WIDTH]));

      // R7
      oor_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en[r] && ce && int'(rd_addr[r*AW +: AW]) >= DEPTH)
          |=> rd_data[r*WIDTH +: WIDTH] == '0);
    end else begin : g_async
      assign rd_data[r*WIDTH +: WIDTH] = stored;
    end
  end
endmodule

// File: tb/tb_mp_ram.sv
`timescale 1ns/1ps
module tb_mp_ram;
  localparam int W = 16, L = 4, D = 12, NW = 2, NR = 3, A = 4;
  localparam logic [2:0] SYNC = 3'b011;
  localparam logic [5:0] TR   = 6'b001011;

  logic clk = 0, rst_n = 0, ce = 1;
  logic [NW*A-1:0] wr_addr = '0;
  logic [NW*W-1:0] wr_data = '0;
  logic [NW*L-1:0] wr_en   = '0;
  logic [NR*A-1:0] rd_addr = '0;
  logic [NR-1:0]   rd_en   = '0;
  logic [NR*W-1:0] rd_data;

  mp_ram #(.WIDTH(W), .LANES(L), .DEPTH(D), .NWR(NW), .NRD(NR),
           .RD_SYNC(SYNC), .TRANSP(TR), .INIT_LEN(4),
           .INIT_DATA(64'h4D4D_3C3C_2B2B_1A1A)) dut (
    .clk(clk), .rst_n(rst_n), .ce(ce), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_en(wr_en), .rd_addr(rd_addr), .rd_en(rd_en), .rd_data(rd_data));

  always #2 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;
  string cur_req = "R9";
  int m[D];
  int q[NR];

  task automatic chk(string tag, logic [W-1:0] got, int exp);
    checks++;
    if (got !== exp[W-1:0]) begin
      errors++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp[W-1:0], $time);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < D; i++) m[i] = 0;
    m[0] = 'h1A1A; m[1] = 'h2B2B; m[2] = 'h3C3C; m[3] = 'h4D4D;
    for (int r = 0; r < NR; r++) q[r] = 0;
  endtask

  function automatic int lane_mask(int l);
    return 'hF << (4 * l);
  endfunction

  task automatic model_step();
    for (int r = 0; r < NR; r++) begin
      if (SYNC[r]) begin
        int ra, v;
        ra = int'(rd_addr[r*A +: A]);
        v  = (ra < D) ? m[ra] : 0;
        if (ra < D && ce)
          for (int w = 0; w < NW; w++)
            if (TR[r*NW + w] && int'(wr_addr[w*A +: A]) == ra)
              for (int l = 0; l < L; l++)
                if (wr_en[w*L + l])
                  v = (v & ~lane_mask(l)) | (int'(wr_data[w*W +: W]) & lane_mask(l));
        if (rd_en[r] && ce) q[r] = v;
      end
    end
    for (int w = 0; w < NW; w++) begin
      int wa;
      wa = int'(wr_addr[w*A +: A]);
      if (wa < D && ce)
        for (int l = 0; l < L; l++)
          if (wr_en[w*L + l])
            m[wa] = (m[wa] & ~lane_mask(l)) | (int'(wr_data[w*W +: W]) & lane_mask(l));
    end
  endtask

  // Inputs are set right after a falling edge; compare around the next edge.
  task automatic tick();
    int a2;
    #1;
    a2 = int'(rd_addr[2*A +: A]);
    chk(cur_req, rd_data[2*W +: W], (a2 < D) ? m[a2] : 0);
    model_step();
    @(negedge clk);
    chk(cur_req, rd_data[0 +: W], q[0]);
    chk(cur_req, rd_data[W +: W], q[1]);
  endtask

  task automatic idle();
    wr_en = '0; rd_en = '0; ce = 1;
  endtask

  task automatic set_wr(int w, int a, int d, int e);
    wr_addr[w*A +: A] = a[A-1:0];
    wr_data[w*W +: W] = d[W-1:0];
    wr_en[w*L +: L]   = e[L-1:0];
  endtask

  task automatic set_rd(int r, int a, bit e);
    rd_addr[r*A +: A] = a[A-1:0];
    rd_en[r] = e;
  endtask

  task automatic do_reset();
    rst_n = 0;
    model_reset();
    set_rd(2, 0, 0);
    #1;
    chk("R9", rd_data[0 +: W], 0);
    chk("R9", rd_data[W +: W], 0);
    chk("R9", rd_data[2*W +: W], 'h1A1A);
    set_rd(2, 3, 0); #1;
    chk("R9", rd_data[2*W +: W], 'h4D4D);
    set_rd(2, 5, 0); #1;
    chk("R9", rd_data[2*W +: W], 0);
    @(negedge clk); @(negedge clk);
    rst_n = 1;
  endtask

  task automatic sweep(string tag);
    cur_req = tag;
    idle();
    for (int a = 0; a < 16; a++) begin
      set_rd(2, a, 0);
      tick();
    end
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();

    // R1: sparse lane enable
    cur_req = "R1";
    idle(); set_wr(0, 6, 'hFFFF, 'b0101); set_rd(2, 6, 0); tick();
    idle(); set_rd(2, 6, 0); set_rd(0, 6, 1); tick();
    idle(); set_wr(1, 1, 'h0000, 'b1000); set_rd(2, 1, 0); tick();
    idle(); set_rd(2, 1, 0); tick();

    // R2: two writers on one address, overlapping lanes
    cur_req = "R2";
    idle(); set_wr(0, 7, 'hAAAA, 'b1111); set_wr(1, 7, 'h5555, 'b0011); tick();
    idle(); set_rd(2, 7, 0); set_rd(1, 7, 1); tick();
    idle(); tick();

    // R3: combinational port sees old word during write, new word after
    cur_req = "R3";
    idle(); set_wr(0, 8, 'h1234, 'b1111); set_rd(2, 8, 1); tick();
    idle(); set_rd(2, 8, 0); tick();

    // R6: port 0 forwards writer 0, port 1 does not (R4 pre-write value)
    cur_req = "R6";
    idle(); set_wr(0, 7, 'hBEEF, 'b0110); set_rd(0, 7, 1); set_rd(1, 7, 1); tick();
    cur_req = "R4";
    idle(); set_rd(0, 7, 1); set_rd(1, 7, 1); tick();
    // both forward writer 1
    cur_req = "R6";
    idle(); set_wr(1, 2, 'hF00D, 'b1001); set_rd(0, 2, 1); set_rd(1, 2, 1); tick();
    // both writers with overlapping lanes into forwarding port 0
    idle(); set_wr(0, 3, 'h1111, 'b1111); set_wr(1, 3, 'h9999, 'b0101);
    set_rd(0, 3, 1); set_rd(1, 3, 1); tick();
    // address mismatch: no forwarding
    idle(); set_wr(0, 4, 'h7777, 'b1111); set_rd(0, 5, 1); tick();

    // R5: enable low holds while writes go on
    cur_req = "R5";
    idle(); set_wr(0, 3, 'hCAFE, 'b1111); set_rd(0, 3, 0); set_rd(1, 3, 0); tick();
    idle(); set_rd(0, 9, 0); set_rd(1, 10, 0); tick();

    // R7: out-of-range reads, including a matching out-of-range write
    cur_req = "R7";
    idle(); set_wr(0, 13, 'hFFFF, 'b1111); set_rd(0, 13, 1); set_rd(1, 14, 1);
    set_rd(2, 15, 0); tick();
    idle(); set_rd(2, 12, 0); tick();

    // R8: out-of-range writes leave everything unchanged
    cur_req = "R8";
    for (int a = 12; a < 16; a++) begin
      idle(); set_wr(0, a, 'h0F0F, 'b1111); set_wr(1, a, 'hF0F0, 'b1111); tick();
    end
    sweep("R8");

    // R10: ce low blocks writes and registered reads
    cur_req = "R10";
    idle(); set_wr(0, 0, 'hDEAD, 'b1111); set_rd(0, 0, 1); set_rd(1, 1, 1);
    ce = 0; set_rd(2, 0, 0); tick();
    idle(); set_rd(2, 0, 0); tick();

    // R6: random traffic with clustered addresses
    cur_req = "R6";
    for (int i = 0; i < 600; i++) begin
      ce = ($urandom % 8) != 0;
      for (int w = 0; w < NW; w++)
        set_wr(w, ($urandom % 6 == 0) ? 12 + $urandom % 4 : $urandom % 6,
               $urandom, $urandom % 16);
      for (int r = 0; r < NR; r++)
        set_rd(r, ($urandom % 8 == 0) ? 12 + $urandom % 4 : $urandom % 6,
               ($urandom % 4) != 0);
      tick();
    end
    sweep("R1");

    // R9: reset restores the initial image
    @(negedge clk);
    do_reset();
    sweep("R9");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule